// File: doc/BRIEF.md
# Output Formatter and Polarisation Demux

This block sits at the end of a summing network. It receives a stream of final and partial array sums in which the two polarisations alternate sample by sample. Every sample carries a polarisation tag. The block does two things to each sample. First, it converts the sample into one of eight output formats, picked by a 3-bit host-set code. A format sets an arithmetic right shift for scaling and then clamps the result to a signed 11-bit range or an unsigned 8-bit range. Second, it groups a polarisation-1 sample with the polarisation-2 sample that follows it, and presents the pair on two separate output channels. Each channel carries one word per pair, so it runs at half the input sample rate.

Several sum lanes travel in parallel under one handshake. Lane 0 carries the full array sum and the remaining lanes carry sub-array sums. Every lane is formatted and split in the same way.

The input and both output channels use valid/ready handshakes. The input is accepted on a clock edge where `in_valid` and `in_ready` are both high. Each output channel holds its data and its valid flag until its own ready is high. The two channels are drained independently. `in_ready` never depends on `in_valid`. It is held low only when the incoming sample would complete a pair and either output channel still holds an undrained word.

Top module: `sum_fmt_demux`

## Requirements
- R1: After reset, `p1_valid` and `p2_valid` are low, `in_ready` is high, and the block expects a polarisation-1 sample.
- R2: Format codes 0 to 3 give signed output. The sample is shifted right arithmetically by the code's value, which rounds toward minus infinity. The result is clamped to the range -1024 to 1023 and emitted as 11-bit two's complement.
- R3: Format codes 4 to 7 give unsigned output. The sample is shifted right arithmetically by (code minus 4). The result is clamped to the range 0 to 255 and emitted zero-extended to 11 bits.
- R4: `in_pol` = 0 marks polarisation 1 and `in_pol` = 1 marks polarisation 2. A tag-0 sample followed by a tag-1 sample forms a pair. Channel 1 receives the tag-0 sample and channel 2 receives the tag-1 sample. Both valid flags rise on the clock edge after the tag-1 sample is accepted.
- R5: Each channel keeps its data stable and its valid flag high until a clock edge on which its own ready is high. Draining one channel does not affect the other.
- R6: `in_ready` is low exactly when a polarisation-2 sample is expected and at least one output channel still holds a word.
- R7: A tag-1 sample that arrives while a polarisation-1 sample is expected is accepted and discarded. No output word is produced.
- R8: A tag-0 sample that arrives while a polarisation-2 sample is expected replaces the held polarisation-1 sample.
- R9: Each sample is formatted with the format code present on the edge where that sample is accepted. The two halves of a pair may therefore use different formats.
- R10: All lanes share the handshake. Each lane is formatted independently from its own input field, and field k occupies bits [k*IN_W +: IN_W] of the input and [k*OUT_W +: OUT_W] of each output.
- R11: While both output readies are held high, samples can be accepted on every clock without a stall, and one pair is produced every two input clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 3 | Output format code, applied to each sample when it is accepted |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_pol | input | 1 | Polarisation tag: 0 = polarisation 1, 1 = polarisation 2 |
| in_sum | input | NLANE*IN_W | Signed sums, one field per lane |
| p1_valid | output | 1 | Polarisation-1 channel holds a word |
| p1_ready | input | 1 | Consumer takes the polarisation-1 word |
| p1_data | output | NLANE*OUT_W | Formatted polarisation-1 words, one field per lane |
| p2_valid | output | 1 | Polarisation-2 channel holds a word |
| p2_ready | input | 1 | Consumer takes the polarisation-2 word |
| p2_data | output | NLANE*OUT_W | Formatted polarisation-2 words, one field per lane |

## Verification
The hardest state to reach from the ports is a pair that is due to complete while one output channel is still occupied. The bench reaches it in three steps. It holds back `p2_ready` only. It then lets channel 1 drain. It then offers the next pair, and observes `in_ready` low before releasing the stalled channel.

The resynchronising cases need deliberately broken tag sequences. The bench sends a tag-1 sample with no tag-0 sample before it, and two tag-0 samples in a row. It then checks which sample actually lands on each channel.

A further pair switches the format code between its two halves, to show that each half is formatted on its own acceptance edge.

// File: rtl/sum_fmt_pkg.sv
package sum_fmt_pkg;

  localparam int FMT_CODE_W = 3;
  localparam int SHIFT_W    = 2;

  typedef struct packed {
    logic               unsigned_out;
    logic [SHIFT_W-1:0] shift;
  } fmt_cfg_t;

  // upper code bit picks the unsigned narrow range, low bits pick the shift
  function automatic fmt_cfg_t decode_fmt(input logic [FMT_CODE_W-1:0] code);
    fmt_cfg_t c;
    c.unsigned_out = code[FMT_CODE_W-1];
    c.shift        = code[SHIFT_W-1:0];
    return c;
  endfunction

endpackage

// File: rtl/sum_fmt_lane.sv
module sum_fmt_lane
  import sum_fmt_pkg::*;
#(
  parameter int IN_W     = 14,
  parameter int OUT_W    = 11,
  parameter int NARROW_W = 8
) (
  input  fmt_cfg_t               cfg,
  input  logic signed [IN_W-1:0] din,
  output logic [OUT_W-1:0]       dout
);

  // wide enough that neither the input nor the clamp limits overflow
  localparam int WW = ((IN_W > OUT_W) ? IN_W : OUT_W) + 1;
  localparam logic signed [WW-1:0] SMAX = WW'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [WW-1:0] SMIN = -SMAX - WW'(1);
  localparam logic signed [WW-1:0] UMAX = WW'((2 ** NARROW_W) - 1);

  logic signed [WW-1:0] wide;
  logic signed [WW-1:0] scaled;

  always_comb begin
    wide   = WW'(din);
    scaled = wide >>> cfg.shift;
    if (cfg.unsigned_out) begin
      if (scaled < 0)         dout = '0;
      else if (scaled > UMAX) dout = OUT_W'(UMAX);
      else                    dout = OUT_W'(scaled[NARROW_W-1:0]);
    end else begin
      if (scaled > SMAX)      dout = OUT_W'(SMAX);
      else if (scaled < SMIN) dout = OUT_W'(SMIN);
      else                    dout = scaled[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/sum_pair_ctrl.sv
module sum_pair_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_pol,
  input  logic p1_busy,
  input  logic p2_busy,
  output logic in_ready,
  output logic take_first,
  output logic take_second,
  output logic phase
);

  logic accept;

  // phase = 1 means a polarisation-1 word is held and its partner is awaited
  assign in_ready    = ~phase | (~p1_busy & ~p2_busy);
  assign accept      = in_valid & in_ready;
  assign take_first  = accept & ~in_pol;
  assign take_second = accept & in_pol & phase;

  always_ff @(posedge clk) begin
    if (!rst_n)           phase <= 1'b0;
    else if (take_first)  phase <= 1'b1;
    else if (take_second) phase <= 1'b0;
  end

endmodule

// File: rtl/sum_chan_valid.sv
module sum_chan_valid (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic ready,
  output logic valid
);

  always_ff @(posedge clk) begin
    if (!rst_n)     valid <= 1'b0;
    else if (load)  valid <= 1'b1;
    else if (ready) valid <= 1'b0;
  end

endmodule

// File: rtl/sum_fmt_demux.sv
module sum_fmt_demux
  import sum_fmt_pkg::*;
#(
  parameter int NLANE    = 3,
  parameter int IN_W     = 14,
  parameter int OUT_W    = 11,
  parameter int NARROW_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [FMT_CODE_W-1:0]  fmt_sel,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_pol,
  input  logic [NLANE*IN_W-1:0]  in_sum,
  output logic                   p1_valid,
  input  logic                   p1_ready,
  output logic [NLANE*OUT_W-1:0] p1_data,
  output logic                   p2_valid,
  input  logic                   p2_ready,
  output logic [NLANE*OUT_W-1:0] p2_data
);

  localparam int NCHAN = 2;

  fmt_cfg_t          cfg;
  logic              take_first;
  logic              take_second;
  logic              phase_q;
  logic [NCHAN-1:0]  ch_ready;
  logic [NCHAN-1:0]  ch_valid;

  assign cfg = decode_fmt(fmt_sel);

  sum_pair_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_pol     (in_pol),
    .p1_busy    (ch_valid[0]),
    .p2_busy    (ch_valid[1]),
    .in_ready   (in_ready),
    .take_first (take_first),
    .take_second(take_second),
    .phase      (phase_q)
  );

  assign ch_ready = {p2_ready, p1_ready};

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    sum_chan_valid u_valid (
      .clk  (clk),
      .rst_n(rst_n),
      .load (take_second),
      .ready(ch_ready[c]),
      .valid(ch_valid[c])
    );
  end

  assign p1_valid = ch_valid[0];
  assign p2_valid = ch_valid[1];

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    logic [OUT_W-1:0] fmt_word;
    logic [OUT_W-1:0] hold_q;
    logic [OUT_W-1:0] c1_q;
    logic [OUT_W-1:0] c2_q;

    sum_fmt_lane #(
      .IN_W    (IN_W),
      .OUT_W   (OUT_W),
      .NARROW_W(NARROW_W)
    ) u_fmt (
      .cfg (cfg),
      .din (in_sum[k*IN_W +: IN_W]),
      .dout(fmt_word)
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_q <= '0;
        c1_q   <= '0;
        c2_q   <= '0;
      end else begin
        if (take_first) hold_q <= fmt_word;
        if (take_second) begin
          c1_q <= hold_q;
          c2_q <= fmt_word;
        end
      end
    end

    assign p1_data[k*OUT_W +: OUT_W] = c1_q;
    assign p2_data[k*OUT_W +: OUT_W] = c2_q;
  end

endmodule

// File: rtl/sum_fmt_demux_chk.sv
module sum_fmt_demux_chk #(
  parameter int DW = 33
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_pol,
  input logic          phase,
  input logic          p1_valid,
  input logic          p1_ready,
  input logic [DW-1:0] p1_data,
  input logic          p2_valid,
  input logic          p2_ready,
  input logic [DW-1:0] p2_data
);

  assert_pair_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p1_valid) |-> $rose(p2_valid));

  assert_pair_rise_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p2_valid) |-> $rose(p1_valid));

  assert_pair_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_pol && phase) |=> (p1_valid && p2_valid));

  assert_hold_ch1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_valid && !p1_ready) |=> (p1_valid && $stable(p1_data)));

  assert_hold_ch2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (p2_valid && !p2_ready) |=> (p2_valid && $stable(p2_data)));

  assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase && (p1_valid || p2_valid)) |-> !in_ready);

  assert_first_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !phase |-> in_ready);

  assert_orphan_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_pol && !phase && !p1_valid) |=> !p1_valid);

endmodule

bind sum_fmt_demux sum_fmt_demux_chk #(.DW(NLANE*OUT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .in_pol  (in_pol),
  .phase   (phase_q),
  .p1_valid(p1_valid),
  .p1_ready(p1_ready),
  .p1_data (p1_data),
  .p2_valid(p2_valid),
  .p2_ready(p2_ready),
  .p2_data (p2_data)
);

// File: tb/tb_sum_fmt_demux.sv
module tb_sum_fmt_demux;

  localparam int CLK_PERIOD = 10;
  localparam int NLANE = 3;
  localparam int IN_W  = 14;
  localparam int OUT_W = 11;
  localparam int NV    = 16;

  // format code, lane-0 polarisation-1 input, expected lane-0 output value
  localparam int VEC_FMT [NV] = '{0, 0, 0, 1, 2, 3, 3, 4, 4, 4, 5, 6, 7, 7, 2, 1};
  localparam int VEC_X   [NV] = '{100, 2000, -2000, -7, 4095, -8192, 8191, 200,
                                  300, -5, 511, 1020, 2047, -1, 17, 2047};
  localparam int VEC_EXP [NV] = '{100, 1023, -1024, -4, 1023, -1024, 1023, 200,
                                  255, 0, 255, 255, 255, 0, 4, 1023};

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [2:0]             fmt_sel = '0;
  logic                   in_valid = 1'b0;
  logic                   in_ready;
  logic                   in_pol = 1'b0;
  logic [NLANE*IN_W-1:0]  in_sum = '0;
  logic                   p1_valid;
  logic                   p1_ready = 1'b1;
  logic [NLANE*OUT_W-1:0] p1_data;
  logic                   p2_valid;
  logic                   p2_ready = 1'b1;
  logic [NLANE*OUT_W-1:0] p2_data;

  int checks = 0;
  int errors = 0;
  int stalls = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sum_fmt_demux #(.NLANE(NLANE), .IN_W(IN_W), .OUT_W(OUT_W), .NARROW_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_pol(in_pol), .in_sum(in_sum),
    .p1_valid(p1_valid), .p1_ready(p1_ready), .p1_data(p1_data),
    .p2_valid(p2_valid), .p2_ready(p2_ready), .p2_data(p2_data)
  );

  function automatic int model(input int code, input int x);
    int y;
    y = x >>> (code % 4);
    if (code >= 4) begin
      if (y < 0) y = 0;
      if (y > 255) y = 255;
    end else begin
      if (y > 1023) y = 1023;
      if (y < -1024) y = -1024;
    end
    return y;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_word(input string req, input logic [OUT_W-1:0] act, input int exp);
    logic [OUT_W-1:0] e;
    e = OUT_W'(exp);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, e);
    end
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send(input logic pol, input int code, input int a, input int b, input int c);
    in_valid = 1'b1;
    in_pol   = pol;
    fmt_sel  = 3'(code);
    in_sum   = {IN_W'(c), IN_W'(b), IN_W'(a)};
    while (!in_ready) begin
      stalls++;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state right after reset
    rst_n = 1'b1;
    check("R1 p1_valid", int'(p1_valid), 0);
    check("R1 p2_valid", int'(p2_valid), 0);
    check("R1 in_ready", int'(in_ready), 1);

    // R2 R3 R4 R10: vector table, one pair per entry
    for (int i = 0; i < NV; i++) begin
      int x;
      int f;
      x = VEC_X[i];
      f = VEC_FMT[i];
      send(1'b0, f, x, x / 3, -(x / 5));
      send(1'b1, f, ~x, x / 7, x / 4);
      check("R4 pair valid ch1", int'(p1_valid), 1);
      check("R4 pair valid ch2", int'(p2_valid), 1);
      check_word((f >= 4) ? "R3 lane0 ch1" : "R2 lane0 ch1", p1_data[0 +: OUT_W], VEC_EXP[i]);
      check_word("R4 lane0 ch2", p2_data[0 +: OUT_W], model(f, ~x));
      check_word("R10 lane1 ch1", p1_data[OUT_W +: OUT_W], model(f, x / 3));
      check_word("R10 lane2 ch1", p1_data[2*OUT_W +: OUT_W], model(f, -(x / 5)));
      check_word("R10 lane1 ch2", p2_data[OUT_W +: OUT_W], model(f, x / 7));
      check_word("R10 lane2 ch2", p2_data[2*OUT_W +: OUT_W], model(f, x / 4));
    end

    // R5 R6: only channel 2 stalls, next pair must wait for it
    @(negedge clk);
    p2_ready = 1'b0;
    send(1'b0, 0, 11, 0, 0);
    send(1'b1, 0, 22, 0, 0);
    @(negedge clk);
    check("R5 ch1 drained", int'(p1_valid), 0);
    check("R5 ch2 held", int'(p2_valid), 1);
    check_word("R5 ch2 data held", p2_data[0 +: OUT_W], 22);
    send(1'b0, 0, 33, 0, 0);
    in_valid = 1'b1; in_pol = 1'b1; in_sum = {IN_W'(0), IN_W'(0), IN_W'(44)};
    #1;
    check("R6 in_ready low while ch2 full", int'(in_ready), 0);
    @(negedge clk);
    check("R6 still stalled", int'(in_ready), 0);
    check_word("R5 ch2 still stable", p2_data[0 +: OUT_W], 22);
    p2_ready = 1'b1;
    @(negedge clk);
    check("R6 ready after drain", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    check_word("R6 pair after stall ch1", p1_data[0 +: OUT_W], 33);
    check_word("R6 pair after stall ch2", p2_data[0 +: OUT_W], 44);

    // R7: orphan tag-1 sample produces nothing and is not paired later
    @(negedge clk);
    send(1'b1, 0, 500, 0, 0);
    check("R7 no output from orphan", int'(p1_valid | p2_valid), 0);
    send(1'b0, 0, 61, 0, 0);
    check("R7 no output after first half", int'(p1_valid), 0);
    send(1'b1, 0, 62, 0, 0);
    check_word("R7 ch1", p1_data[0 +: OUT_W], 61);
    check_word("R7 ch2", p2_data[0 +: OUT_W], 62);

    // R8: second tag-0 sample replaces the first
    send(1'b0, 0, 71, 0, 0);
    send(1'b0, 0, 72, 0, 0);
    check("R8 no output yet", int'(p1_valid), 0);
    send(1'b1, 0, 73, 0, 0);
    check_word("R8 ch1 newest", p1_data[0 +: OUT_W], 72);
    check_word("R8 ch2", p2_data[0 +: OUT_W], 73);

    // R9: format changes between the halves of a pair
    send(1'b0, 0, 300, 0, 0);
    send(1'b1, 4, 300, 0, 0);
    check_word("R9 ch1 signed", p1_data[0 +: OUT_W], 300);
    check_word("R9 ch2 unsigned", p2_data[0 +: OUT_W], 255);

    // R11: back-to-back samples with both readies high
    stalls = 0;
    send(1'b0, 1, 80, 0, 0);
    send(1'b1, 1, 81, 0, 0);
    send(1'b0, 1, 82, 0, 0);
    send(1'b1, 1, 83, 0, 0);
    check("R11 no stalls", stalls, 0);
    check_word("R11 last ch1", p1_data[0 +: OUT_W], 41);
    check_word("R11 last ch2", p2_data[0 +: OUT_W], 41);

    // R1: reset in the middle of a pair clears everything
    send(1'b0, 0, 90, 0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    send(1'b1, 0, 91, 0, 0);
    check("R1 held half cleared by reset", int'(p1_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule